// File: doc/BRIEF.md
# Sample Ring Writer with Status Flags

This block takes signed 16-bit conversion results, one per `res_valid` pulse, and writes them through a plain memory write port into a circular buffer. Software places the buffer through a small register bus by giving a base byte address and a length counted in samples. The block keeps four sticky status flags: a new result is available, the first half of the buffer has been filled, the whole buffer has been filled, and a result arrived while the ring writer was switched off.

Software clears a flag by writing 1 to its bit. An enable mask decides which flags reach the single interrupt output. With the mask at zero, software polls the flag register instead. Each sample goes to an even byte address. After the last slot the ring writer returns to the base and keeps writing. Settings written while the writer is running take effect at once and do not stop it, so the buffer can hold samples taken under old and new settings.

Top module: `smp_ring_dma`

## Requirements
- R1: After reset every register reads zero, all flags are clear, `irq` is low and `mem_we` is low. Register addresses are: 0 base, 1 length, 2 control (bit 0 turns the ring writer on), 3 flags, 4 interrupt enable mask, 5 last result (read-only).
- R2: A result sampled while the writer is on is written one clock later with `mem_we` high, `mem_wdata` equal to the result and `mem_addr` equal to base + 2 × slot. Bit 0 of a written base is dropped, so every address is even.
- R3: The slot starts at 0, rises by one per written result, and returns to 0 after slot L−1, where L is the length. Writing continues after the return.
- R4: A write to slot floor(L/2)−1 sets the half flag (flag bit 1).
- R5: A write to slot L−1 sets the full flag (flag bit 2).
- R6: Every sampled result, whether or not the writer is on, sets the ready flag (flag bit 0). The same result becomes readable, sign-extended to 32 bits, at register 5.
- R7: A result sampled while the writer is off sets the overflow flag (flag bit 3) and produces no memory write.
- R8: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R9: `irq` is high exactly when some flag is set and its bit in the enable mask is 1. With the mask at zero, `irq` stays low and the flags remain readable.
- R10: If a new event and a software clear hit the same flag in the same clock, the flag ends up set.
- R11: Turning the writer on (control bit 0 going from 0 to 1) returns the slot to 0, so the next write lands at the base.
- R12: A length of 0 or 1 behaves as a length of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-clock strobe marking a new conversion result |
| res_data | input | 16 | Signed conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address, always even |
| mem_wdata | output | 16 | Memory write data |
| irq | output | 1 | Combined interrupt |

## Verification
The ring writer is run over every length from 2 to 9. Each length gets an odd base and a stream of more than two full turns of distinct positive and negative samples. This separates a wrong slot step, a wrong wrap point and a half or full mark that is off by one; odd lengths in particular expose a rounding error in the half mark. Lengths 0 and 1 confirm the clamp. A run that is switched off and on again mid-buffer confirms the return to the base. Results fed with the writer off, clears written with mixed ones and zeros, a clear that collides with a new result, and masks that select one flag at a time separate the overflow, clear, priority and interrupt paths.

// File: rtl/smp_ring_pkg.sv
package smp_ring_pkg;

  localparam int FLAG_N  = 4;
  localparam int FL_RDY  = 0;
  localparam int FL_HALF = 1;
  localparam int FL_FULL = 2;
  localparam int FL_OVF  = 3;

  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_LEN  = 3'd1;
  localparam logic [2:0] RA_CTRL = 3'd2;
  localparam logic [2:0] RA_FLAG = 3'd3;
  localparam logic [2:0] RA_IE   = 3'd4;
  localparam logic [2:0] RA_DATA = 3'd5;

  localparam int unsigned MIN_LEN = 2;

  // effective ring length after the lower clamp
  function automatic int unsigned ring_len(input int unsigned len);
    return (len < MIN_LEN) ? MIN_LEN : len;
  endfunction

  function automatic int unsigned ring_last(input int unsigned len);
    return ring_len(len) - 1;
  endfunction

  // last slot of the first half
  function automatic int unsigned ring_half(input int unsigned len);
    return (ring_len(len) / 2) - 1;
  endfunction

  // byte address of a half-word slot
  function automatic int unsigned ring_addr(input int unsigned base,
                                            input int unsigned idx);
    return base + (idx << 1);
  endfunction

  // slot after idx; also recovers when the length shrinks below idx
  function automatic int unsigned ring_step(input int unsigned idx,
                                            input int unsigned len);
    return (idx >= ring_last(len)) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/smp_ring_regs.sv
module smp_ring_regs
  import smp_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [FLAG_N-1:0] flags,
  input  logic [DATA_W-1:0] data,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              dma_en_q,
  output logic              en_pulse,
  output logic [FLAG_N-1:0] ie_q,
  output logic              flag_wr,
  output logic [FLAG_N-1:0] clr_mask
);

  logic wr_base, wr_len, wr_ctrl, wr_ie;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_base  = reg_wr && (reg_addr == RA_BASE);
  assign wr_len   = reg_wr && (reg_addr == RA_LEN);
  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_ie    = reg_wr && (reg_addr == RA_IE);
  assign flag_wr  = reg_wr && (reg_addr == RA_FLAG);

  assign en_pulse = wr_ctrl && reg_wdata[0] && !dma_en_q;
  assign clr_mask = flag_wr ? reg_wdata[FLAG_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      len_q    <= '0;
      dma_en_q <= 1'b0;
      ie_q     <= '0;
    end else begin
      if (wr_base) base_q   <= {reg_wdata[ADDR_W-1:1], 1'b0};
      if (wr_len)  len_q    <= reg_wdata[LEN_W-1:0];
      if (wr_ctrl) dma_en_q <= reg_wdata[0];
      if (wr_ie)   ie_q     <= reg_wdata[FLAG_N-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_BASE: reg_rdata = REG_W'(base_q);
      RA_LEN:  reg_rdata = REG_W'(len_q);
      RA_CTRL: reg_rdata = REG_W'(dma_en_q);
      RA_FLAG: reg_rdata = REG_W'(flags);
      RA_IE:   reg_rdata = REG_W'(ie_q);
      RA_DATA: reg_rdata = REG_W'($signed(data));
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/smp_ring_ptr.sv
module smp_ring_ptr
  import smp_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              dma_en,
  input  logic              en_pulse,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              wr_evt,
  output logic              half_evt,
  output logic              full_evt,
  output logic              ovf_evt
);

  localparam int IDX_W = LEN_W;

  logic [IDX_W-1:0] idx_q;
  logic             at_half, at_last;

  assign at_half  = (32'(idx_q) == ring_half(32'(len)));
  assign at_last  = (32'(idx_q) >= ring_last(32'(len)));

  assign wr_evt   = res_valid && dma_en;
  assign ovf_evt  = res_valid && !dma_en;
  assign half_evt = wr_evt && at_half;
  assign full_evt = wr_evt && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (en_pulse) begin
      idx_q <= '0;
    end else if (wr_evt) begin
      idx_q <= IDX_W'(ring_step(32'(idx_q), 32'(len)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr_evt;
      if (wr_evt) begin
        mem_addr  <= ADDR_W'(ring_addr(32'(base), 32'(idx_q)));
        mem_wdata <= res_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (res_valid) data_q <= res_data;
  end

endmodule

// File: rtl/smp_ring_flags.sv
module smp_ring_flags
  import smp_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set_vec,
  input  logic [FLAG_N-1:0] clr_mask,
  input  logic [FLAG_N-1:0] ie,
  output logic [FLAG_N-1:0] flags_q,
  output logic              irq
);

  // a set in the same clock as a clear leaves the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | set_vec;
  end

  assign irq = |(flags_q & ie);

endmodule

// File: rtl/smp_ring_dma.sv
module smp_ring_dma
  import smp_ring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq
);

  // named internal events, also used by the bound checker
  logic [ADDR_W-1:0] base_w;
  logic [LEN_W-1:0]  len_w;
  logic              dma_en_w;
  logic              en_pulse_w;
  logic [FLAG_N-1:0] ie_w;
  logic              flag_wr_w;
  logic [FLAG_N-1:0] clr_mask_w;
  logic [FLAG_N-1:0] flags_w;
  logic [FLAG_N-1:0] set_vec_w;
  logic [DATA_W-1:0] data_w;
  logic              wr_evt_w, half_evt_w, full_evt_w, ovf_evt_w;

  smp_ring_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .REG_W(REG_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flags_w),
    .data      (data_w),
    .reg_rdata (reg_rdata),
    .base_q    (base_w),
    .len_q     (len_w),
    .dma_en_q  (dma_en_w),
    .en_pulse  (en_pulse_w),
    .ie_q      (ie_w),
    .flag_wr   (flag_wr_w),
    .clr_mask  (clr_mask_w)
  );

  smp_ring_ptr #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .dma_en    (dma_en_w),
    .en_pulse  (en_pulse_w),
    .base      (base_w),
    .len       (len_w),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .data_q    (data_w),
    .wr_evt    (wr_evt_w),
    .half_evt  (half_evt_w),
    .full_evt  (full_evt_w),
    .ovf_evt   (ovf_evt_w)
  );

  always_comb begin
    set_vec_w          = '0;
    set_vec_w[FL_RDY]  = res_valid;
    set_vec_w[FL_HALF] = half_evt_w;
    set_vec_w[FL_FULL] = full_evt_w;
    set_vec_w[FL_OVF]  = ovf_evt_w;
  end

  smp_ring_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec_w),
    .clr_mask (clr_mask_w),
    .ie       (ie_w),
    .flags_q  (flags_w),
    .irq      (irq)
  );

endmodule

// File: rtl/smp_ring_chk.sv
module smp_ring_chk
  import smp_ring_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              dma_en,
  input logic [FLAG_N-1:0] clr_mask,
  input logic [FLAG_N-1:0] flags,
  input logic [FLAG_N-1:0] ie,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              irq
);

  // R2
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_addr[0]);

  // R7
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(res_valid && dma_en));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !dma_en) |=> flags[FL_OVF]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && clr_mask[FL_RDY]) |=> flags[FL_RDY]);

  // R8
  for (genvar k = 0; k < FLAG_N; k++) begin : g_keep
    keep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !clr_mask[k]) |=> flags[k]);
  end

  // R9
  irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ie[FL_RDY]) |=> irq);

  // R9
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |-> !irq);

endmodule

bind smp_ring_dma smp_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .dma_en    (dma_en_w),
  .clr_mask  (clr_mask_w),
  .flags     (flags_w),
  .ie        (ie_w),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .irq       (irq)
);

// File: tb/test_smp_ring_dma.sv
`timescale 1ns/1ps
module test_smp_ring_dma;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  smp_ring_dma i_smp_ring_dma (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [RW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [DW-1:0] d);
    @(negedge clk);
    res_valid = 1'b1; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [RW-1:0] rv;
    logic [DW-1:0] d;
    logic [AW-1:0] base;
    int            slot;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(3'd3, rv); chk("R1", "flags after reset", rv, 0);
    rd_reg(3'd2, rv); chk("R1", "control after reset", rv, 0);
    rd_reg(3'd0, rv); chk("R1", "base after reset", rv, 0);
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "mem_we after reset", mem_we, 0);

    // R2 R3 R4 R5 R6: sweep lengths 2..9
    for (int L = 2; L <= 9; L++) begin
      base = AW'(16'h0100 + L * 64);
      wr_reg(3'd2, 0);
      wr_reg(3'd1, RW'(L));
      wr_reg(3'd0, RW'(base | 16'h0001));
      wr_reg(3'd2, 1);
      slot = 0;
      for (int n = 0; n <= 2 * L; n++) begin
        wr_reg(3'd3, 32'hF);
        d = DW'(L * 1000 - n * 4097);
        pulse(d);
        chk("R2", "mem_we", mem_we, 1);
        chk("R2", "mem_addr", mem_addr, base + 2 * slot);
        chk("R2", "mem_wdata", mem_wdata, d);
        rd_reg(3'd3, rv);
        chk("R4/R5", "flags after write", rv,
            1 | ((slot == L / 2 - 1) ? 2 : 0) | ((slot == L - 1) ? 4 : 0));
        rd_reg(3'd5, rv);
        chk("R6", "data register", rv, {{(RW-DW){d[DW-1]}}, d});
        slot = (slot == L - 1) ? 0 : slot + 1; // R3 wrap
      end
    end

    // R12 lengths 0 and 1 clamp to 2
    for (int L = 0; L <= 1; L++) begin
      base = 16'h0800;
      wr_reg(3'd2, 0);
      wr_reg(3'd1, RW'(L));
      wr_reg(3'd0, RW'(base));
      wr_reg(3'd2, 1);
      for (int n = 0; n < 3; n++) begin
        wr_reg(3'd3, 32'hF);
        pulse(DW'(n + 7));
        chk("R12", "clamped address", mem_addr, base + 2 * (n % 2));
        rd_reg(3'd3, rv);
        chk("R12", "clamped flags", rv, (n % 2 == 0) ? 3 : 5);
      end
    end

    // R11 re-enable returns to base
    base = 16'h0A00;
    wr_reg(3'd2, 0);
    wr_reg(3'd1, 6);
    wr_reg(3'd0, RW'(base));
    wr_reg(3'd2, 1);
    for (int n = 0; n < 3; n++) pulse(DW'(n));
    chk("R11", "addr before re-enable", mem_addr, base + 4);
    wr_reg(3'd2, 0);
    wr_reg(3'd2, 1);
    pulse(16'h1234);
    chk("R11", "addr after re-enable", mem_addr, base);

    // R7 overflow with writer off
    wr_reg(3'd2, 0);
    wr_reg(3'd3, 32'hF);
    pulse(16'h8001);
    chk("R7", "no memory write when off", mem_we, 0);
    rd_reg(3'd3, rv);
    chk("R7", "overflow and ready flags", rv, 9);
    rd_reg(3'd5, rv);
    chk("R6", "data register when off", rv, 32'hFFFF8001);

    // R9 polled mode then masks
    wr_reg(3'd4, 0);
    chk("R9", "irq with mask zero", irq, 0);
    wr_reg(3'd4, 4);
    chk("R9", "irq with only full enabled", irq, 0);
    wr_reg(3'd4, 8);
    chk("R9", "irq with overflow enabled", irq, 1);

    // R8 zero writes have no effect, one clears only its bit
    wr_reg(3'd3, 0);
    rd_reg(3'd3, rv);
    chk("R8", "flags after zero write", rv, 9);
    wr_reg(3'd3, 8);
    rd_reg(3'd3, rv);
    chk("R8", "flags after clearing overflow", rv, 1);
    chk("R9", "irq after clear", irq, 0);

    // R10 set and clear collide on the ready flag
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 1;
    res_valid = 1'b1; res_data = 16'h0042;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; res_valid = 1'b0;
    rd_reg(3'd3, rv);
    chk("R10", "ready survives collision", rv[0], 1);
    wr_reg(3'd3, 32'hF);
    rd_reg(3'd3, rv);
    chk("R8", "flags after full clear", rv, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule